// File: doc/BRIEF.md
# Coherent Split-Read Transfer Byte Counters

This block keeps two byte counters for a storage-card host controller. The first counter tracks bytes exchanged with the card. The second tracks bytes exchanged with the system bus. Each counter is cleared when a transfer starts. On every cycle that its strobe is high, a counter adds the byte amount given with that strobe.

Software reads the counters through a small read port. The port carries an enable, a counter select and a half select, and it returns registered data together with a valid flag. A parameter sets the read width to the full counter width or to half of it. In half-width mode, reading the lower half of either counter also captures that counter's upper half into one holding register, which is shared by both counters. A later upper-half read returns this captured value, so the two halves always come from the same instant. A second parameter enables an area-saving option. With it, any read made while a transfer is active returns zero.

Top module: `xfer_byte_counters`

## Requirements
- R1: After reset both counters, the shared holding register, `rd_vld_o` and `rd_data_o` are all 0.
- R2: On a cycle where a counter's strobe is high and no transfer start is present, the counter adds the strobe's byte amount. The sum wraps modulo 2^CNT_W.
- R3: `xfer_start_i` clears both counters to 0, and any increment in the same cycle is discarded. When start and done arrive in the same cycle, start wins and the transfer stays active.
- R4: In full-width mode, a read returns the whole counter in the cycle after `rd_en_i`, with `rd_vld_o` high. The value is the one held before any increment in the read's own cycle. `rd_sel_i` chooses the counter: 0 for the card counter, 1 for the bus counter.
- R5: In half-width mode, a read with `rd_hi_i`=0 returns the selected counter's bits [15:0]. The same read stores that counter's bits [31:16] in the shared holding register.
- R6: In half-width mode, a read with `rd_hi_i`=1 returns the holding register, not the live upper bits. A lower-half read of either counter overwrites the holding register. An upper-half read with no earlier lower-half read returns the last captured value, which is 0 after reset.
- R7: With the area-saving option on, the transfer counts as active from the cycle after `xfer_start_i` up to and including the cycle of `xfer_done_i`. Any read sampled while active returns 0, and a lower-half read made while active loads 0 into the holding register.
- R8: In full-width mode, `rd_hi_i` has no effect on the returned data.
- R9: In a cycle with no read, `rd_vld_o` drops to 0 and `rd_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_start_i | input | 1 | Start of a new transfer; clears both counters |
| xfer_done_i | input | 1 | End of the current transfer |
| card_inc_vld_i | input | 1 | Card-side increment strobe |
| card_inc_bytes_i | input | INC_W | Bytes added to the card counter |
| bus_inc_vld_i | input | 1 | Bus-side increment strobe |
| bus_inc_bytes_i | input | INC_W | Bytes added to the bus counter |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 1 | Counter select: 0 for card, 1 for bus |
| rd_hi_i | input | 1 | Half select for half-width reads: 1 for the upper half |
| rd_vld_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| rd_data_o | output | DATA_W | Read data: CNT_W/2 bits in half-width mode, CNT_W bits otherwise |

## Verification
The bench builds two instances and drives them with the same stimulus. The first runs in half-width mode with the area-saving option on. The second runs in full-width mode with the option off, so each read made during a transfer shows the masked value on one instance and the live value on the other. Both instances set the increment width equal to the counter width. This lets a few strobes carry a counter across the 2^32 boundary and set its upper half to values that are easy to tell apart, which is what the shared holding register needs when it is tested across both counters.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  typedef enum logic {
    SRC_CARD = 1'b0,
    SRC_BUS  = 1'b1
  } cnt_src_e;

  localparam int unsigned NUM_CNT = 2;
endpackage

// File: rtl/xbc_counter.sv
module xbc_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_vld_i,
  input  logic [INC_W-1:0] inc_bytes_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (inc_vld_i) cnt_q <= cnt_q + CNT_W'(inc_bytes_i);
  end

  assign cnt_o = cnt_q;

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  assert_wrap_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_vld_i && !clr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'($past(inc_bytes_i)))));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_vld_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/xbc_xfer_ctl.sv
module xbc_xfer_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (done_i)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/xbc_rd_port.sv
module xbc_rd_port
  import xbc_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter bit          BUS16    = 1'b0,
  parameter bit          AREA_OPT = 1'b0,
  parameter int unsigned DATA_W   = CNT_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input  logic                      busy_i,
  input  logic                      rd_en_i,
  input  logic                      rd_sel_i,
  input  logic                      rd_hi_i,
  output logic                      rd_vld_o,
  output logic [DATA_W-1:0]         rd_data_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  cnt_src_e         src;
  logic             masked;
  logic [CNT_W-1:0] sel_val;
  logic [DATA_W-1:0] rd_data_q;
  logic             rd_vld_q;

  assign src    = cnt_src_e'(rd_sel_i);
  assign masked = AREA_OPT && busy_i;

  always_comb begin
    sel_val = (src == SRC_BUS) ? cnt_i[1] : cnt_i[0];
    if (masked) sel_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_en_i;
  end

  generate
    if (BUS16) begin : g_narrow
      logic [HALF_W-1:0] hold_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q    <= '0;
          rd_data_q <= '0;
        end else if (rd_en_i) begin
          if (!rd_hi_i) begin
            rd_data_q <= sel_val[HALF_W-1:0];
            hold_q    <= sel_val[CNT_W-1:HALF_W];
          end else begin
            rd_data_q <= masked ? '0 : hold_q;
          end
        end
      end

      assert_lo_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !rd_hi_i && !masked) |=>
          (hold_q == $past(rd_sel_i ? cnt_i[1][CNT_W-1:HALF_W] : cnt_i[0][CNT_W-1:HALF_W])));

      assert_hi_from_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_hi_i && !masked) |=> (rd_data_o == $past(hold_q)));

      assert_hold_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_en_i && !rd_hi_i) |=> $stable(hold_q));
    end else begin : g_wide
      logic unused_hi;
      assign unused_hi = rd_hi_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_data_q <= '0;
        else if (rd_en_i) rd_data_q <= sel_val;
      end

      assert_full_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !masked) |=> (rd_data_o == $past(rd_sel_i ? cnt_i[1] : cnt_i[0])));
    end
  endgenerate

  assign rd_vld_o  = rd_vld_q;
  assign rd_data_o = rd_data_q;

  assert_mask_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && masked) |=> (rd_data_o == '0));

  assert_no_read_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_vld_o && $stable(rd_data_o)));
endmodule

// File: rtl/xfer_byte_counters.sv
module xfer_byte_counters
  import xbc_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned INC_W    = 16,
  parameter bit          BUS16    = 1'b0,
  parameter bit          AREA_OPT = 1'b0,
  localparam int unsigned DATA_W  = BUS16 ? CNT_W / 2 : CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  input  logic              card_inc_vld_i,
  input  logic [INC_W-1:0]  card_inc_bytes_i,
  input  logic              bus_inc_vld_i,
  input  logic [INC_W-1:0]  bus_inc_bytes_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  logic              rd_hi_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_CNT-1:0]            inc_vld;
  logic [NUM_CNT-1:0][INC_W-1:0] inc_bytes;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic                          busy;

  assign inc_vld   = {bus_inc_vld_i, card_inc_vld_i};
  assign inc_bytes = {bus_inc_bytes_i, card_inc_bytes_i};

  xbc_xfer_ctl u_xfer_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (xfer_start_i),
    .done_i  (xfer_done_i),
    .busy_o  (busy)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    xbc_counter #(
      .CNT_W (CNT_W),
      .INC_W (INC_W)
    ) u_counter (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (xfer_start_i),
      .inc_vld_i   (inc_vld[g]),
      .inc_bytes_i (inc_bytes[g]),
      .cnt_o       (cnt[g])
    );
  end

  xbc_rd_port #(
    .CNT_W    (CNT_W),
    .BUS16    (BUS16),
    .AREA_OPT (AREA_OPT),
    .DATA_W   (DATA_W)
  ) u_rd_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .busy_i    (busy),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .rd_hi_i   (rd_hi_i),
    .rd_vld_o  (rd_vld_o),
    .rd_data_o (rd_data_o)
  );

  initial begin
    assert_half_width_R5: assert (CNT_W % 2 == 0 && INC_W <= CNT_W);
  end
endmodule

// File: tb/xfer_byte_counters_tb.sv
module xfer_byte_counters_tb;
  localparam int CLK_P = 10;
  localparam int CW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, done_i = 0, cv_i = 0, bv_i = 0, rd_en = 0, rd_sel = 0, rd_hi = 0;
  logic [CW-1:0] cb_i = '0, bb_i = '0;
  logic        n_vld, w_vld;
  logic [15:0] n_data;
  logic [31:0] w_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  // half-width with area option
  xfer_byte_counters #(.CNT_W(CW), .INC_W(CW), .BUS16(1'b1), .AREA_OPT(1'b1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .xfer_start_i(start_i), .xfer_done_i(done_i),
    .card_inc_vld_i(cv_i), .card_inc_bytes_i(cb_i), .bus_inc_vld_i(bv_i), .bus_inc_bytes_i(bb_i),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_hi_i(rd_hi), .rd_vld_o(n_vld), .rd_data_o(n_data));

  // full-width, no masking
  xfer_byte_counters #(.CNT_W(CW), .INC_W(CW), .BUS16(1'b0), .AREA_OPT(1'b0)) u_dut_w (
    .clk_i(clk_i), .rst_ni(rst_ni), .xfer_start_i(start_i), .xfer_done_i(done_i),
    .card_inc_vld_i(cv_i), .card_inc_bytes_i(cb_i), .bus_inc_vld_i(bv_i), .bus_inc_bytes_i(bb_i),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_hi_i(rd_hi), .rd_vld_o(w_vld), .rd_data_o(w_data));

  // reference model
  logic [31:0] m_cnt [2];
  logic        m_busy;
  logic [15:0] m_hold, m_d16;
  logic [31:0] m_d32, m_val;
  logic        m_vld;
  string       tag_n, tag_w;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_busy = 0; m_hold = 0;
      m_d16 = 0; m_d32 = 0; m_vld = 0; tag_n = "R1"; tag_w = "R1";
    end else begin
      m_vld = rd_en;
      if (rd_en) begin
        m_val = m_cnt[rd_sel];
        m_d32 = m_val;
        tag_w = rd_hi ? "R8" : "R4";
        if (m_busy) m_val = 0;
        if (!rd_hi) begin
          m_d16 = m_val[15:0];
          m_hold = m_val[31:16];
          tag_n = m_busy ? "R7" : "R5";
        end else begin
          m_d16 = m_busy ? 16'h0 : m_hold;
          tag_n = m_busy ? "R7" : "R6";
        end
      end else begin
        tag_n = "R9"; tag_w = "R9";
      end
      if (start_i) begin
        m_cnt[0] = 0; m_cnt[1] = 0;
      end else begin
        if (cv_i) m_cnt[0] = m_cnt[0] + cb_i;
        if (bv_i) m_cnt[1] = m_cnt[1] + bb_i;
      end
      if (start_i) m_busy = 1;
      else if (done_i) m_busy = 0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(tag_n, "narrow vld", {31'b0, n_vld}, {31'b0, m_vld});
      chk(tag_n, "narrow data", {16'b0, n_data}, {16'b0, m_d16});
      chk(tag_w, "wide vld", {31'b0, w_vld}, {31'b0, m_vld});
      chk(tag_w, "wide data", w_data, m_d32);
    end
  end

  task automatic idle();
    start_i = 0; done_i = 0; cv_i = 0; bv_i = 0; rd_en = 0; rd_hi = 0; rd_sel = 0;
    @(negedge clk_i);
  endtask

  task automatic rd(input logic sel, input logic hi);
    start_i = 0; done_i = 0; cv_i = 0; bv_i = 0;
    rd_en = 1; rd_sel = sel; rd_hi = hi;
    @(negedge clk_i);
    rd_en = 0;
  endtask

  task automatic cyc(input logic st, input logic dn, input logic cv, input logic [31:0] cb,
                     input logic bv, input logic [31:0] bb, input logic re, input logic sel, input logic hi);
    start_i = st; done_i = dn; cv_i = cv; cb_i = cb; bv_i = bv; bb_i = bb;
    rd_en = re; rd_sel = sel; rd_hi = hi;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state at the ports
    chk("R1", "reset narrow vld", {31'b0, n_vld}, 32'h0);
    chk("R1", "reset narrow data", {16'b0, n_data}, 32'h0);
    chk("R1", "reset wide vld", {31'b0, w_vld}, 32'h0);
    chk("R1", "reset wide data", w_data, 32'h0);
    rst_ni = 1;
    idle();
    // R6: upper read before any lower read returns reset capture
    rd(1'b0, 1'b1);
    rd(1'b0, 1'b0); rd(1'b1, 1'b0); rd(1'b1, 1'b1);
    idle();
    // R2 R3: start, increments, done, read with coincident increment (R4)
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'd100, 1, 32'd4096, 0, 0, 0);
    cyc(0, 0, 1, 32'd28, 1, 32'h0003_0000, 1, 0, 0);   // R7 masked on narrow
    cyc(0, 0, 1, 32'h0005_0001, 0, 0, 1, 1, 1);
    cyc(0, 1, 0, 0, 1, 32'd7, 1, 1, 0);                 // read in done cycle still masked
    idle();
    rd(1'b0, 1'b0); rd(1'b0, 1'b1);                      // R5 R6
    rd(1'b0, 1'b0);
    rd(1'b1, 1'b0);                                      // R6 shared hold overwritten
    rd(1'b0, 1'b1);
    // R6 stale hold after increment between halves (no transfer active)
    rd(1'b1, 1'b0);
    cyc(0, 0, 0, 0, 1, 32'h0100_0000, 0, 0, 0);
    rd(1'b1, 1'b1);
    rd(1'b1, 1'b0);
    cyc(0, 0, 1, 32'd5, 1, 32'd9, 1, 0, 0);              // R4 read before coincident increment
    // R8: rd_hi ignored in full width
    rd(1'b0, 1'b1); rd(1'b1, 1'b1);
    // R2 wrap
    cyc(0, 0, 1, 32'hFFFF_FFF0, 1, 32'hFFFF_0000, 0, 0, 0);
    cyc(0, 0, 1, 32'h0000_0020, 1, 32'h0002_0000, 1, 0, 0);
    rd(1'b0, 1'b0); rd(1'b0, 1'b1); rd(1'b1, 1'b0); rd(1'b1, 1'b1);
    // R3: start with coincident increment, then start+done together
    cyc(1, 0, 1, 32'd55, 1, 32'd66, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 32'd3, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'd11, 0, 0, 1, 0, 0);                 // still active: masked
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    rd(1'b0, 1'b0); rd(1'b0, 1'b1); rd(1'b1, 1'b0);
    // R9: no read keeps data
    idle(); idle();
    rd(1'b1, 1'b1);
    idle(); idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule